// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block runs one link integrity machine for each twisted-pair port of a multiport repeater. It counts millisecond ticks to find two conditions. The first is a transmitter that has been quiet long enough to need a keep-alive link pulse. The second is a receiver that has heard nothing, neither a packet nor a pulse, for long enough that the segment must be treated as broken. A broken port stays marked down until it hears a packet or a short unbroken train of link pulses. While a port is marked down, its received data is kept off the repeat path.

Each port can switch off its receive-side check through a management bit. With the check off, the port is held good however long it stays silent, so the repeater can work with older segments that never send link pulses. The transmit side behaves the same in every state: every port gets its keep-alive pulses whether it is up, down or has its check switched off. After reset, every port begins in the down state.

Top module: `link_integrity_mon`

## Requirements
- R1: After reset is released, every port reports link_good_o = 0 and lp_req_o = 0.
- R2: A port whose tx_active_i stays low asserts lp_req_o for exactly one clock cycle. This happens in the cycle after its 16th ms_tick_i since the last transmit activity or the last pulse request, so requests repeat every 16 ticks.
- R3: Any cycle with tx_active_i high restarts that port's transmit idle count at zero, even when ms_tick_i is high in the same cycle.
- R4: Pulse requests are issued in the same way whether the port is good, failed, or has chk_en_i low.
- R5: A good port with chk_en_i = 1 that sees no rx_data_i and no rx_pulse_i for 100 ms ticks drops link_good_o in the cycle after the 100th tick. Any rx_data_i or rx_pulse_i restarts this count at zero.
- R6: A failed port that sees rx_data_i high for one cycle raises link_good_o in the next cycle.
- R7: A failed port raises link_good_o in the cycle after its 4th consecutive rx_pulse_i. After three pulses it stays failed.
- R8: While a failed port is collecting pulses, 65 ms ticks without a pulse discard the pulses collected so far. A gap of 64 ticks keeps them.
- R9: rx_rep_o[i] follows rx_data_i[i] only while link_good_o[i] is 1. It is 0 while the port is failed.
- R10: With chk_en_i = 0, a port reports link_good_o = 1 from the next cycle onward, however long it stays silent. When chk_en_i returns to 1, the 100-tick silence count restarts from zero.
- R11: Each port's link state and pulse requests depend only on that port's own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ms_tick_i | input | 1 | One-cycle strobe once per millisecond |
| rx_data_i | input | NPORTS | Per-port received packet activity |
| rx_pulse_i | input | NPORTS | Per-port single normal link pulse detected (one-cycle strobe) |
| tx_active_i | input | NPORTS | Per-port transmitter busy |
| chk_en_i | input | NPORTS | Per-port receive link check enable (1 = check on) |
| lp_req_o | output | NPORTS | Per-port one-cycle request to send a link pulse |
| link_good_o | output | NPORTS | Per-port link state, 1 = good |
| rx_rep_o | output | NPORTS | Per-port receive data admitted to the repeat path |

## Verification
The bench goes after the off-by-one edges of every window. It checks the 15th and 16th idle tick, the 99th and 100th silent tick, and a 64-tick versus a 65-tick pulse gap. A counter compared one step early or late would move a request or a link drop by one tick, or would keep or discard a pulse train wrongly. It also checks that a transmit strobe landing on a tick wins over the tick, that a third pulse does not recover a port, and that a repeat path opened in the same cycle as the recovering packet is caught. Finally, it checks that re-enabling the receive check restarts the silence window from zero, where a faulty design would drop the port at once.

// File: rtl/lim_pkg.sv
package lim_pkg;

  typedef enum logic {
    LNK_FAIL = 1'b0,
    LNK_GOOD = 1'b1
  } lnk_state_e;

  function automatic int unsigned lim_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lim_rst_sync.sv
module lim_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/lim_tx_timer.sv
module lim_tx_timer #(
  parameter int unsigned TX_IDLE_MS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic tx_active_i,
  output logic lp_req_o
);

  localparam int unsigned CW = (TX_IDLE_MS > 1) ? $clog2(TX_IDLE_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TX_IDLE_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (tx_active_i) begin
      cnt_d = '0;
    end else if (ms_tick_i) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign lp_req_o = req_q;

endmodule

// File: rtl/lim_rx_fsm.sv
module lim_rx_fsm
  import lim_pkg::*;
#(
  parameter int unsigned RX_FAIL_MS     = 100,
  parameter int unsigned PULSE_GAP_MS   = 65,
  parameter int unsigned RECOVER_PULSES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic rx_data_i,
  input  logic rx_pulse_i,
  input  logic chk_en_i,
  output logic link_good_o
);

  localparam int unsigned SPAN = lim_max(RX_FAIL_MS, PULSE_GAP_MS);
  localparam int unsigned CW   = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam int unsigned PW   = (RECOVER_PULSES > 1) ? $clog2(RECOVER_PULSES) : 1;
  localparam logic [CW-1:0] FAIL_LAST  = CW'(RX_FAIL_MS - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(PULSE_GAP_MS - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(RECOVER_PULSES - 1);

  lnk_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pc_d  = pc_q;
    if (!chk_en_i) begin
      st_d  = LNK_GOOD;
      cnt_d = '0;
      pc_d  = '0;
    end else if (st_q == LNK_GOOD) begin
      if (rx_data_i || rx_pulse_i) begin
        cnt_d = '0;
      end else if (ms_tick_i) begin
        if (cnt_q == FAIL_LAST) begin
          st_d  = LNK_FAIL;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      if (rx_data_i) begin
        st_d  = LNK_GOOD;
        cnt_d = '0;
        pc_d  = '0;
      end else if (rx_pulse_i) begin
        cnt_d = '0;
        if (pc_q == PULSE_LAST) begin
          st_d = LNK_GOOD;
          pc_d = '0;
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end else if (ms_tick_i && (pc_q != '0)) begin
        if (cnt_q == GAP_LAST) begin
          cnt_d = '0;
          pc_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LNK_FAIL;
      cnt_q <= '0;
      pc_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
    end
  end

  assign link_good_o = (st_q == LNK_GOOD);

endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int unsigned NPORTS         = 2,
  parameter int unsigned TX_IDLE_MS     = 16,
  parameter int unsigned RX_FAIL_MS     = 100,
  parameter int unsigned PULSE_GAP_MS   = 65,
  parameter int unsigned RECOVER_PULSES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic [NPORTS-1:0] rx_data_i,
  input  logic [NPORTS-1:0] rx_pulse_i,
  input  logic [NPORTS-1:0] tx_active_i,
  input  logic [NPORTS-1:0] chk_en_i,
  output logic [NPORTS-1:0] lp_req_o,
  output logic [NPORTS-1:0] link_good_o,
  output logic [NPORTS-1:0] rx_rep_o
);

  logic rst_sync_n;

  lim_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    lim_tx_timer #(.TX_IDLE_MS(TX_IDLE_MS)) u_tx (
      .clk_i       (clk_i),
      .rst_ni      (rst_sync_n),
      .ms_tick_i   (ms_tick_i),
      .tx_active_i (tx_active_i[p]),
      .lp_req_o    (lp_req_o[p])
    );

    lim_rx_fsm #(
      .RX_FAIL_MS     (RX_FAIL_MS),
      .PULSE_GAP_MS   (PULSE_GAP_MS),
      .RECOVER_PULSES (RECOVER_PULSES)
    ) u_rx (
      .clk_i       (clk_i),
      .rst_ni      (rst_sync_n),
      .ms_tick_i   (ms_tick_i),
      .rx_data_i   (rx_data_i[p]),
      .rx_pulse_i  (rx_pulse_i[p]),
      .chk_en_i    (chk_en_i[p]),
      .link_good_o (link_good_o[p])
    );

    assign rx_rep_o[p] = rx_data_i[p] & link_good_o[p];
  end

endmodule

// File: rtl/lim_checker.sv
module lim_checker #(
  parameter int unsigned NPORTS = 2
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              ms_tick_i,
  input logic [NPORTS-1:0] rx_data_i,
  input logic [NPORTS-1:0] rx_pulse_i,
  input logic [NPORTS-1:0] tx_active_i,
  input logic [NPORTS-1:0] chk_en_i,
  input logic [NPORTS-1:0] lp_req_o,
  input logic [NPORTS-1:0] link_good_o
);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R2: a request lasts a single cycle
    p_req_single_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
      lp_req_o[p] |=> !lp_req_o[p]);

    // R3: a request never follows a cycle of transmit activity
    p_req_after_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
      lp_req_o[p] |-> !$past(tx_active_i[p]));

    // R5: a port only drops on a tick with its check enabled
    p_drop_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
      $fell(link_good_o[p]) |-> ($past(ms_tick_i) && $past(chk_en_i[p])));

    // R6/R7: a port only comes up after an rx event or a disabled check
    p_rise_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
      $rose(link_good_o[p]) |->
        ($past(rx_data_i[p]) || $past(rx_pulse_i[p]) || !$past(chk_en_i[p])));

    // R10: check disabled holds the port good
    p_disabled_good_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
      ($past(rst_n) && !$past(chk_en_i[p])) |-> link_good_o[p]);
  end

endmodule

bind link_integrity_mon lim_checker #(.NPORTS(NPORTS)) u_lim_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .ms_tick_i   (ms_tick_i),
  .rx_data_i   (rx_data_i),
  .rx_pulse_i  (rx_pulse_i),
  .tx_active_i (tx_active_i),
  .chk_en_i    (chk_en_i),
  .lp_req_o    (lp_req_o),
  .link_good_o (link_good_o)
);

// File: tb/link_integrity_mon_bench.sv
module link_integrity_mon_bench;

  localparam int unsigned NP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic [NP-1:0] rxd, rxp, txa, chk;
  logic [NP-1:0] lpr, good, rep;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  link_integrity_mon #(.NPORTS(NP)) u_link_integrity_mon (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ms_tick_i   (tick),
    .rx_data_i   (rxd),
    .rx_pulse_i  (rxp),
    .tx_active_i (txa),
    .chk_en_i    (chk),
    .lp_req_o    (lpr),
    .link_good_o (good),
    .rx_rep_o    (rep)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic pulse(input int p);
    @(negedge clk) rxp[p] = 1'b1;
    @(negedge clk) rxp[p] = 1'b0;
  endtask

  task automatic pulses(input int p, input int n);
    for (int i = 0; i < n; i++) pulse(p);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0;
    rxd = '0; rxp = '0; txa = '0; chk = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 link_good", good, 0);
    check("R1 lp_req", lpr, 0);

    // R2/R4: pulse requests while both ports are failed
    ticks(15);
    check("R2 no req before 16th tick", lpr, 0);
    ticks(1);
    check("R2 req after 16th tick (R4 port failed)", lpr, 2'b11);
    @(negedge clk);
    check("R2 req one cycle", lpr, 0);
    ticks(15);
    check("R2 period 15", lpr, 0);
    ticks(1);
    check("R2 period 16", lpr, 2'b11);

    // R3: transmit activity coinciding with a tick restarts port 0
    ticks(10);
    @(negedge clk) begin tick = 1'b1; txa[0] = 1'b1; end
    @(negedge clk) begin tick = 1'b0; txa[0] = 1'b0; end
    ticks(5);
    check("R3 R11 port1 only", lpr, 2'b10);
    ticks(10);
    check("R3 port0 not yet", lpr, 0);
    ticks(1);
    check("R3 port0 after restart", lpr, 2'b01);

    // R8: a 65-tick gap discards collected pulses on port 1
    pulses(1, 2);
    ticks(65);
    pulses(1, 2);
    check("R8 gap 65 discards", good, 0);
    pulses(1, 2);
    check("R8 recovery after fresh four", good, 2'b10);

    // R7/R11: four pulses recover port 0
    pulses(0, 3);
    check("R7 three pulses not enough", good, 2'b10);
    pulse(0);
    check("R7 fourth pulse recovers", good, 2'b11);

    // R5: silence window and restart by an event
    ticks(50);
    pulse(1);
    ticks(49);
    check("R5 99 ticks still good", good, 2'b11);
    ticks(1);
    check("R5 100th tick fails port0", good, 2'b10);
    ticks(49);
    check("R5 restart kept port1", good, 2'b10);
    ticks(1);
    check("R5 port1 fails", good, 0);

    // R9/R6: repeat path blocked during failure, packet recovers
    @(negedge clk) rxd[0] = 1'b1;
    #1 check("R9 blocked while failed", rep[0], 0);
    @(negedge clk);
    check("R6 packet recovers", good[0], 1);
    check("R9 passes when good", rep[0], 1);
    rxd[0] = 1'b0;
    #1 check("R9 follows data", rep[0], 0);

    // R8: a 64-tick gap keeps collected pulses
    pulses(1, 3);
    ticks(64);
    pulse(1);
    check("R8 gap 64 kept", good, 2'b11);

    // R10: disabled check holds good, re-enable restarts window
    ticks(100);
    check("R10 setup both failed", good, 0);
    @(negedge clk) chk[0] = 1'b0;
    @(negedge clk);
    check("R10 disabled goes good", good, 2'b01);
    ticks(200);
    check("R10 disabled stays good", good, 2'b01);
    @(negedge clk) chk[0] = 1'b1;
    ticks(99);
    check("R10 window restarted", good, 2'b01);
    ticks(1);
    check("R10 fails after full window", good, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule